// File: doc/BRIEF.md
# Locking Packet Timestamp Capture Unit

This unit takes a snapshot of a free-running 64-bit time counter when a marked event packet crosses the timestamp point. Transmit and receive have separate channels. Each channel has an enable, a held flag, and a capture register that software reads as two 32-bit words. After a channel has captured a stamp it locks. It ignores every later event until software reads the upper word of that capture. Each direction therefore has at most one outstanding stamp, and every stamp belongs to exactly one packet.

Software reaches the unit through a simple register port with one cycle per access. Read data is combinational from the address. A read has a side effect only in the clock cycle in which `reg_rd` is sampled high. There is no back-pressure: an access completes in the cycle it is presented, and the event strobes are plain single-cycle pulses. A transmit capture sets a sticky pending bit. The interrupt output is that bit gated by a mask bit.

Register map (word addresses):
- 0 is control. bit0 is the transmit enable, bit1 the receive enable, bit2 the transmit held flag (read-only), bit3 the receive held flag (read-only) and bit4 the interrupt mask.
- 1 is the pending register. bit0 is the transmit-stamp pending bit, and writing 1 to it clears it.
- 2 and 3 are the transmit low and high words. 4 and 5 are the receive low and high words.
- Other addresses read as zero.

Top module: `tstamp_capture_unit`

## Requirements
- R1: After reset, control (address 0) and pending (address 1) both read 0, every capture word reads 0, and `irq` is 0.
- R2: When the receive enable (control bit1) is 1, and an `rx_event` is sampled while the receive held flag (control bit3) is 0, the capture takes the `time_now` value of that same clock edge and the held flag reads 1 from the next cycle on.
- R3: While a held flag is 1, later events in that direction are ignored and the captured words keep their values while the time counter moves.
- R4: A read of the low word (address 2 or 4) leaves the held flag set. A read of the high word (address 3 or 5) returns the held upper bits and clears that direction's held flag from the next cycle on, whether or not the low word was read.
- R5: When a direction's enable bit is 0, events in that direction capture nothing and leave its held flag at 0.
- R6: The transmit channel (enable bit0, held bit2, words at addresses 2 and 3, strobe `tx_event`) behaves the same way as the receive channel and is independent of it.
- R7: The low word returns bits 31:0 of the captured time and the high word returns bits 63:32.
- R8: A transmit capture sets pending bit0. `irq` equals pending bit0 AND mask (control bit4). Writing 1 to pending bit0 clears it, and a capture in the same cycle as that write wins.
- R9: An event that arrives in the same cycle as a high-word read of its direction is ignored: after that cycle the held flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time counter value |
| tx_event | input | 1 | Transmit event packet at the stamp point |
| rx_event | input | 1 | Receive event packet at the stamp point |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe, which drives the read side effects |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Transmit timestamp interrupt |

## Verification
Most internal faults in this unit show up within one cycle as a wrong held flag in the control word. A lock that never sets shows as bit2 or bit3 staying 0 after an enabled event. A lock that never releases shows as the flag staying 1 after a high-word read. A capture register that keeps sampling while locked shows as a low word that changes between two reads taken without a release in between. An interrupt fault shows up on `irq` in the cycle after the capture or after the clearing write.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_TX  = 0;
  localparam int unsigned CH_RX  = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_PEND  = 3'd1,
    A_TX_LO = 3'd2,
    A_TX_HI = 3'd3,
    A_RX_LO = 3'd4,
    A_RX_HI = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tsc_channel.sv
module tsc_channel #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              evt,
  input  logic              release_i,
  input  logic [TIME_W-1:0] time_now,
  output logic [TIME_W-1:0] stamp,
  output logic              held,
  output logic              captured
);
  assign captured = en && evt && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp <= '0;
      held  <= 1'b0;
    end else if (captured) begin
      stamp <= time_now;
      held  <= 1'b1;
    end else if (release_i) begin
      held  <= 1'b0;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    held && !release_i |=> held && $stable(stamp));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    held && release_i |=> !held);
  assert_no_capture_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !held |=> !held);
  assert_capture_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && evt && !held |=> held && stamp == $past(time_now));
endmodule

// File: rtl/tsc_regfile.sv
module tsc_regfile
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [TIME_W-1:0] stamp [NUM_CH],
  input  logic [NUM_CH-1:0] held,
  input  logic              tx_captured,
  output logic [NUM_CH-1:0] en,
  output logic [NUM_CH-1:0] release_o,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  logic mask_q, pend_q;
  logic wr_ctrl, clr_pend;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign clr_pend = reg_wr && (reg_addr == A_PEND) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '0;
      mask_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en     <= reg_wdata[NUM_CH-1:0];
        mask_q <= reg_wdata[4];
      end
      if (tx_captured)   pend_q <= 1'b1;
      else if (clr_pend) pend_q <= 1'b0;
    end
  end

  assign release_o[CH_TX] = reg_rd && (reg_addr == A_TX_HI);
  assign release_o[CH_RX] = reg_rd && (reg_addr == A_RX_HI);
  assign irq = pend_q && mask_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  begin
        reg_rdata[NUM_CH-1:0]      = en;
        reg_rdata[2*NUM_CH-1:NUM_CH] = held;
        reg_rdata[4]               = mask_q;
      end
      A_PEND:  reg_rdata[0] = pend_q;
      A_TX_LO: reg_rdata = stamp[CH_TX][WORD_W-1:0];
      A_TX_HI: reg_rdata = stamp[CH_TX][TIME_W-1:WORD_W];
      A_RX_LO: reg_rdata = stamp[CH_RX][WORD_W-1:0];
      A_RX_HI: reg_rdata = stamp[CH_RX][TIME_W-1:WORD_W];
      default: reg_rdata = '0;
    endcase
  end

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q);
  assert_pend_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_captured |=> pend_q);
endmodule

// File: rtl/tstamp_capture_unit.sv
module tstamp_capture_unit
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              tx_event,
  input  logic              rx_event,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);
  logic [TIME_W-1:0] stamp [NUM_CH];
  logic [NUM_CH-1:0] held, en, rel, cap, evt;

  assign evt[CH_TX] = tx_event;
  assign evt[CH_RX] = rx_event;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tsc_channel #(.TIME_W(TIME_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en[c]),
      .evt      (evt[c]),
      .release_i(rel[c]),
      .time_now (time_now),
      .stamp    (stamp[c]),
      .held     (held[c]),
      .captured (cap[c])
    );
  end

  tsc_regfile #(.WORD_W(WORD_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rd     (reg_rd),
    .stamp      (stamp),
    .held       (held),
    .tx_captured(cap[CH_TX]),
    .en         (en),
    .release_o  (rel),
    .reg_rdata  (reg_rdata),
    .irq        (irq)
  );

  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel[CH_RX] && held[CH_RX] |=> !held[CH_RX]);
endmodule

// File: tb/tb_tstamp_capture_unit.sv
module tb_tstamp_capture_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] time_now = '0;
  logic        tx_event = 0, rx_event = 0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  tstamp_capture_unit dut (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 0;
    #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pulse(input bit tx, input logic [63:0] t);
    @(negedge clk);
    time_now = t;
    if (tx) tx_event = 1; else rx_event = 1;
    @(negedge clk);
    tx_event = 0; rx_event = 0;
    time_now = t + 64'd1000;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(0, d); check(d, 0, "R1 ctrl");
    peek(1, d); check(d, 0, "R1 pend");
    peek(5, d); check(d, 0, "R1 rx_hi");
    check({31'd0, irq}, 0, "R1 irq");
  endtask

  task automatic t_rx_disabled();
    logic [31:0] d;
    pulse(0, 64'h1);
    peek(0, d); check(d[3], 0, "R5 rx disabled no hold");
  endtask

  task automatic t_rx_capture_lock();
    logic [31:0] d;
    wr(0, 32'h2);
    pulse(0, 64'h11223344_55667788);
    peek(0, d); check(d[3:2], 2'b10, "R2 rx held only");
    peek(4, d); check(d, 32'h55667788, "R7 rx low");
    peek(5, d); check(d, 32'h11223344, "R7 rx high");
    pulse(0, 64'hAAAA0000_BBBB0000);
    peek(4, d); check(d, 32'h55667788, "R3 rx locked low");
    rd(4, d);
    peek(0, d); check(d[3], 1, "R4 low read keeps hold");
    rd(5, d); check(d, 32'h11223344, "R4 high read value");
    peek(0, d); check(d[3], 0, "R4 high read releases");
    pulse(0, 64'h00000002_00000003);
    peek(4, d); check(d, 32'h3, "R2 recapture after release");
    rd(5, d);
    wr(0, 32'h0);
    pulse(0, 64'h9);
    peek(0, d); check(d[3], 0, "R5 enable cleared");
  endtask

  task automatic t_tx_irq();
    logic [31:0] d;
    wr(0, 32'h11);
    pulse(1, 64'hCAFE0001_DEAD0002);
    peek(0, d); check(d[3:2], 2'b01, "R6 tx held rx not");
    peek(2, d); check(d, 32'hDEAD0002, "R6 tx low");
    peek(3, d); check(d, 32'hCAFE0001, "R6 tx high");
    check({31'd0, irq}, 1, "R8 irq raised");
    peek(1, d); check(d, 1, "R8 pend set");
    wr(1, 32'h1);
    check({31'd0, irq}, 0, "R8 irq cleared");
    rd(3, d);
    wr(0, 32'h01);
    pulse(1, 64'h5);
    peek(1, d); check(d, 1, "R8 pend with mask off");
    check({31'd0, irq}, 0, "R8 irq masked");
    wr(1, 32'h1);
    rd(3, d);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(0, 32'h2);
    pulse(0, 64'h7);
    @(negedge clk);
    reg_addr = 5; reg_rd = 1; rx_event = 1; time_now = 64'h8;
    @(negedge clk);
    reg_rd = 0; rx_event = 0;
    peek(0, d); check(d[3], 0, "R9 event during release ignored");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_rx_disabled();
        t_rx_capture_lock();
        t_tx_irq();
        t_same_cycle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule